// File: doc/BRIEF.md
# Priority-Encoded Bidirectional Shift Register

This block is a parameterised register (four bits by default) that, on each rising clock edge, either keeps its value, takes a new parallel word, moves its contents one place towards the least significant bit, or moves them one place towards the most significant bit. A datapath controller asks for an operation through three independent request lines: load, shift-right and shift-left. It may raise any mix of them, and the block settles the conflict by a fixed priority.

A small combinational encoder turns the three requests into a two-bit operation code. In front of every flip-flop, a four-way selector uses that code to pick the bit's next value. Two serial fill inputs supply the bit that enters at the vacated end during a shift. The code is also driven out on a port, so surrounding logic or a checker can see which operation the register will perform at the coming edge. An active-high synchronous reset clears the register and overrides every request.

Top module: `prio_shreg`

## Requirements
- R1: While `rst` is high at a rising edge, `q` becomes all zeros at that edge, whatever the requests, data and fill inputs are.
- R2: With no request active, `op_code` is 2'b00 and `q` keeps its value across the edge.
- R3: With only `load_req` active, `op_code` is 2'b01 and `q` takes `par_in` at the edge.
- R4: With `shr_req` active and `load_req` inactive, `op_code` is 2'b10. At the edge bit WIDTH-1 takes `shr_fill` and every bit i below it takes the old bit i+1.
- R5: With only `shl_req` active, `op_code` is 2'b11. At the edge bit 0 takes `shl_fill` and every bit i above it takes the old bit i-1.
- R6: When `load_req` is active together with either shift request or both, the load is performed (`op_code` 2'b01) and the shifts have no effect.
- R7: When both shift requests are active and `load_req` is inactive, the right shift is performed (`op_code` 2'b10) and the left shift has no effect.
- R8: `q` changes only at a rising clock edge. A change of requests or data between edges leaves `q` unchanged until the next edge.
- R9: `op_code` follows the request inputs combinationally in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| load_req | input | 1 | Parallel load request (highest priority) |
| shr_req | input | 1 | Shift toward bit 0 request |
| shl_req | input | 1 | Shift toward the top bit request (lowest priority) |
| par_in | input | WIDTH | Word captured by a load |
| shr_fill | input | 1 | Bit entering the top position on a right shift |
| shl_fill | input | 1 | Bit entering bit 0 on a left shift |
| q | output | WIDTH | Register contents |
| op_code | output | 2 | Encoded operation for the coming edge: 00 hold, 01 load, 10 right, 11 left |

## Verification
Load and both shifts can be requested in the same cycle, so the bench drives all eight request combinations, every simultaneous pair included, from several register states. The fill bits and the parallel word are chosen to differ from what a losing operation would produce. Each result is judged against a reference model written as a plain priority chain, both for the code seen before the edge and for the word seen after it. A long pseudo-random request sequence then mixes conflicts with resets. It also moves the inputs between edges to show that only the edge updates the register.

// File: rtl/prio_shreg_pkg.sv
package prio_shreg_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_RIGHT = 2'b10,
        OP_LEFT  = 2'b11
    } op_e;

    typedef struct packed {
        logic load;
        logic right;
        logic left;
    } req_t;

    // Fixed Boolean encoding: load over right, right over left.
    function automatic op_e encode_req(req_t r);
        logic hi_bit;
        logic lo_bit;
        hi_bit = ~r.load & (r.right | r.left);
        lo_bit = r.load | (~r.right & r.left);
        return op_e'({hi_bit, lo_bit});
    endfunction

endpackage

// File: rtl/prio_shreg_enc.sv
module prio_shreg_enc
    import prio_shreg_pkg::*;
(
    input  req_t req,
    output op_e  op
);
    always_comb begin
        op = encode_req(req);
    end
endmodule

// File: rtl/prio_shreg_cell.sv
module prio_shreg_cell
    import prio_shreg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  sel,
    input  logic par_d,
    input  logic upper_d,
    input  logic lower_d,
    output logic q_bit
);
    logic nxt;

    always_comb begin
        case (sel)
            OP_HOLD:  nxt = q_bit;
            OP_LOAD:  nxt = par_d;
            OP_RIGHT: nxt = upper_d;
            OP_LEFT:  nxt = lower_d;
            default:  nxt = q_bit;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q_bit <= 1'b0;
        else     q_bit <= nxt;
    end
endmodule

// File: rtl/prio_shreg.sv
module prio_shreg
    import prio_shreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_req,
    input  logic             shr_req,
    input  logic             shl_req,
    input  logic [WIDTH-1:0] par_in,
    input  logic             shr_fill,
    input  logic             shl_fill,
    output logic [WIDTH-1:0] q,
    output logic [1:0]       op_code
);
    localparam int TOP = WIDTH - 1;

    req_t req;
    op_e  op_sel;

    assign req = '{load: load_req, right: shr_req, left: shl_req};

    prio_shreg_enc u_enc (
        .req (req),
        .op  (op_sel)
    );

    assign op_code = op_sel;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic upper_d;
        logic lower_d;
        if (i == TOP) begin : g_top
            assign upper_d = shr_fill;
        end else begin : g_mid_hi
            assign upper_d = q[i+1];
        end
        if (i == 0) begin : g_bot
            assign lower_d = shl_fill;
        end else begin : g_mid_lo
            assign lower_d = q[i-1];
        end

        prio_shreg_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .sel     (op_sel),
            .par_d   (par_in[i]),
            .upper_d (upper_d),
            .lower_d (lower_d),
            .q_bit   (q[i])
        );
    end
endmodule

// File: rtl/prio_shreg_chk.sv
module prio_shreg_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             load_req,
    input logic             shr_req,
    input logic             shl_req,
    input logic [WIDTH-1:0] par_in,
    input logic             shr_fill,
    input logic             shl_fill,
    input logic [WIDTH-1:0] q,
    input logic [1:0]       op_code
);
    assert_clear_R1: assert property (@(posedge clk)
        rst |=> (q == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!load_req && !shr_req && !shl_req) |=> $stable(q));

    assert_load_R3_R6: assert property (@(posedge clk) disable iff (rst)
        load_req |=> (q == $past(par_in)));

    assert_right_R4_R7: assert property (@(posedge clk) disable iff (rst)
        (!load_req && shr_req) |=> (q == {$past(shr_fill), $past(q[WIDTH-1:1])}));

    assert_left_R5: assert property (@(posedge clk) disable iff (rst)
        (!load_req && !shr_req && shl_req) |=> (q == {$past(q[WIDTH-2:0]), $past(shl_fill)}));

    assert_code_R9: assert property (@(posedge clk) disable iff (rst)
        (load_req ? (op_code == 2'b01) :
         shr_req  ? (op_code == 2'b10) :
         shl_req  ? (op_code == 2'b11) : (op_code == 2'b00)));
endmodule

bind prio_shreg prio_shreg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_req (load_req),
    .shr_req  (shr_req),
    .shl_req  (shl_req),
    .par_in   (par_in),
    .shr_fill (shr_fill),
    .shl_fill (shl_fill),
    .q        (q),
    .op_code  (op_code)
);

// File: tb/prio_shreg_tb.sv
module prio_shreg_tb;
    localparam int WIDTH      = 4;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [WIDTH-1:0] exp_q;
        string            tag;
    } item_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             load_req = 1'b0;
    logic             shr_req = 1'b0;
    logic             shl_req = 1'b0;
    logic [WIDTH-1:0] par_in = '0;
    logic             shr_fill = 1'b0;
    logic             shl_fill = 1'b0;
    logic [WIDTH-1:0] q;
    logic [1:0]       op_code;

    int checks = 0;
    int errors = 0;
    logic [WIDTH-1:0] model_q = '0;
    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_shreg #(.WIDTH(WIDTH)) u_dut (
        .clk(clk), .rst(rst), .load_req(load_req), .shr_req(shr_req),
        .shl_req(shl_req), .par_in(par_in), .shr_fill(shr_fill),
        .shl_fill(shl_fill), .q(q), .op_code(op_code)
    );

    task automatic check(input bit ok, input string tag, input logic [WIDTH-1:0] act,
                         input logic [WIDTH-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Monitor: compare each result one edge after it was requested.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(q === it.exp_q, it.tag, q, it.exp_q);
            end
        end
    end

    // Driver: one cycle of stimulus, with the expected outcome pushed to the scoreboard.
    task automatic step(input bit r, input bit ld, input bit sr, input bit sl,
                        input logic [WIDTH-1:0] d, input bit fr, input bit fl);
        item_t it;
        logic [WIDTH-1:0] nq;
        logic [1:0] exp_code;
        @(negedge clk);
        rst = r; load_req = ld; shr_req = sr; shl_req = sl;
        par_in = d; shr_fill = fr; shl_fill = fl;
        #1;
        if (ld)      exp_code = 2'b01;
        else if (sr) exp_code = 2'b10;
        else if (sl) exp_code = 2'b11;
        else         exp_code = 2'b00;
        if (!r) check(op_code === exp_code, "R9 op_code", WIDTH'(op_code), WIDTH'(exp_code));
        check(q === model_q, "R8 q before edge", q, model_q);
        nq = model_q;
        if (r) begin
            nq = '0;            it.tag = "R1 reset";
        end else if (ld) begin
            nq = d;             it.tag = (sr || sl) ? "R6 load wins" : "R3 load";
        end else if (sr) begin
            for (int i = 0; i < WIDTH - 1; i++) nq[i] = model_q[i+1];
            nq[WIDTH-1] = fr;   it.tag = sl ? "R7 right wins" : "R4 right";
        end else if (sl) begin
            for (int i = WIDTH - 1; i > 0; i--) nq[i] = model_q[i-1];
            nq[0] = fl;         it.tag = "R5 left";
        end else begin
            it.tag = "R2 hold";
        end
        it.exp_q = nq;
        model_q  = nq;
        sb.push_back(it);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Reset state (R1), with conflicting requests present.
        step(1, 1, 1, 1, 4'hF, 1, 1);
        step(1, 0, 0, 0, 4'h0, 0, 0);
        // Every request combination from several starting states.
        for (int s = 0; s < 3; s++) begin
            for (int c = 0; c < 8; c++) begin
                logic [WIDTH-1:0] seed;
                seed = (s == 0) ? 4'b1001 : (s == 1) ? 4'b0110 : 4'b1100;
                step(0, 1, 0, 0, seed, 0, 0);
                step(0, c[2], c[1], c[0], ~seed, ~seed[0], ~seed[WIDTH-1]);
            end
        end
        // Walk a one across with right shifts, then back with left shifts.
        step(0, 1, 0, 0, 4'b1000, 0, 0);
        for (int i = 0; i < WIDTH; i++) step(0, 0, 1, 0, 4'hF, 0, 1);
        step(0, 0, 0, 1, 4'h0, 0, 1);
        for (int i = 0; i < WIDTH; i++) step(0, 0, 0, 1, 4'hF, 1, 0);
        // Reset overriding a load mid-stream (R1).
        step(0, 1, 0, 0, 4'hA, 0, 0);
        step(1, 1, 0, 0, 4'h5, 1, 1);
        // Pseudo-random mix of conflicts and occasional resets.
        for (int n = 0; n < 300; n++) begin
            logic [31:0] rv;
            rv = $urandom;
            step(rv[7:0] == 8'd0, rv[8], rv[9], rv[10], rv[14:11], rv[15], rv[16]);
        end
        step(0, 0, 0, 0, 4'h0, 0, 0);
        repeat (3) @(posedge clk);
        #2;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule